// File: doc/BRIEF.md
# Error-Correcting Byte-Lane Static Memory Core

A clocked model of a word-wide static memory. Each stored word is 16 data bits plus 5 Hamming check bits. It has an active-low primary select and an active-high secondary select; a build parameter can drop the secondary select. It also has active-low write, output and per-byte lane enables, and an active-low sleep input that freezes all access while the array keeps its contents. Reads are registered, with a latency of one cycle. Each read passes the stored word through a single-error corrector. A flag registered with the data reports that a correction took place. The corrected value is never written back to the array.

Writes may cover one lane or both. For a single-lane write, the corrected copy of the other lane is combined with the new byte, and fresh check bits are computed over the whole word. An undriven output is modelled by a per-lane valid qualifier rather than by high impedance. A test port flips any single stored bit, data or check, so that faults can be injected.

Top module: `eccram_core`

## Requirements
- R1: A write takes place on a clock edge when the chip is selected, sleep is high, the write enable is low and both lanes are enabled. A read issued after it returns the written word one cycle after the read edge, with laneValid = 2'b11.
- R2: A write with only the upper lane enabled (hiByteEnN low) changes bits 15:8 of the word. A write with only the lower lane enabled changes bits 7:0. The other lane keeps its stored value.
- R3: A read sets laneValid to {upper enabled, lower enabled}. rdData bits belonging to a lane that is not enabled read as zero.
- R4: laneValid is 2'b00 after any edge at which any of these holds: chipEnN is high, chipEn2 is low (dual-select build), outEnN is high, or both lane enables are high. A write attempted while deselected leaves the word unchanged.
- R5: While sleepN is low, reads give laneValid = 2'b00 and errFlag = 0, and writes are ignored. Once sleepN is high again, the stored contents read back unchanged.
- R6: A read of a word with one flipped bit returns the original data. The flipped bit may be any of the 21 codeword positions, check bits included; injBit selects it as codeword position minus one, from 0 to 20. errFlag is 1 in the same cycle as that data.
- R7: A correction is not written back. A second read of the same faulty word flags errFlag again.
- R8: A single-lane write to a faulty word keeps the corrected value of the other lane and stores a clean codeword. The following read shows errFlag = 0.
- R9: During reset, rdData = 0, laneValid = 2'b00 and errFlag = 0.
- R10: An edge with wrEnN low is a write and never a read, even with outEnN low. The next cycle shows laneValid = 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the read registers |
| chipEnN | input | 1 | Primary select, active low |
| chipEn2 | input | 1 | Secondary select, active high (dual-select build only) |
| wrEnN | input | 1 | Write enable, active low |
| outEnN | input | 1 | Output enable, active low |
| hiByteEnN | input | 1 | Upper lane (15:8) enable, active low |
| loByteEnN | input | 1 | Lower lane (7:0) enable, active low |
| sleepN | input | 1 | Sleep request, active low; contents retained |
| addr | input | ADDR_W | Word address |
| wrData | input | 16 | Write data |
| injEn | input | 1 | Test: flip one stored bit this edge (ignored when a write occurs) |
| injAddr | input | ADDR_W | Test: address of the bit to flip |
| injBit | input | 5 | Test: codeword bit index 0..20 to flip |
| rdData | output | 16 | Corrected read data, disabled lanes zero |
| laneValid | output | 2 | Per-lane output-valid qualifier {upper, lower} |
| errFlag | output | 1 | A correction was applied to this read |

## Verification
A wrong internal state has two visible forms. A corrupted codeword or a bad lane merge shows at the port as wrong data or a wrong errFlag one cycle after the next read of that address. A fault in the access decode shows as a wrong laneValid one cycle after the offending edge. Faults in the array are invisible until the address is read, so the bench re-reads each address after every disturbance: a byte write, a deselected or sleeping write, an injection.

// File: rtl/eccram_pkg.sv
package eccram_pkg;
  localparam int DATA_W = 16;
  localparam int CHK_W  = 5;
  localparam int CW_W   = DATA_W + CHK_W;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic [1:0] lanes;
  } strobe_t;

  function automatic logic [CW_W-1:0] hamEncode(input logic [DATA_W-1:0] d);
    logic [CW_W-1:0] cw;
    logic par;
    int k;
    cw = '0;
    k = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p-1] = d[k];
        k++;
      end
    end
    for (int c = 0; c < CHK_W; c++) begin
      par = 1'b0;
      for (int p = 1; p <= CW_W; p++)
        if (((p >> c) & 1) == 1) par = par ^ cw[p-1];
      cw[(1 << c) - 1] = par;
    end
    return cw;
  endfunction

  function automatic logic [CHK_W-1:0] hamSyndrome(input logic [CW_W-1:0] cw);
    logic [CHK_W-1:0] syn;
    syn = '0;
    for (int p = 1; p <= CW_W; p++)
      if (cw[p-1]) syn = syn ^ CHK_W'(p);
    return syn;
  endfunction

  function automatic logic [DATA_W-1:0] hamCorrect(input logic [CW_W-1:0] cw,
                                                   input logic [CHK_W-1:0] syn);
    logic [CW_W-1:0] fixed;
    logic [DATA_W-1:0] d;
    int k;
    fixed = cw;
    for (int p = 1; p <= CW_W; p++)
      if (syn == CHK_W'(p)) fixed[p-1] = ~fixed[p-1];
    d = '0;
    k = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[k] = fixed[p-1];
        k++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/eccram_ctrl.sv
module eccram_ctrl
  import eccram_pkg::*;
#(
  parameter bit DUAL_CE = 1'b1
) (
  input  logic    chipEnN,
  input  logic    chipEn2,
  input  logic    wrEnN,
  input  logic    outEnN,
  input  logic    hiByteEnN,
  input  logic    loByteEnN,
  input  logic    sleepN,
  output strobe_t strb
);
  logic selected;
  logic awake;
  logic [1:0] laneReq;

  generate
    if (DUAL_CE) begin : g_dual
      assign selected = !chipEnN && chipEn2;
    end else begin : g_single
      logic unusedSel;
      assign unusedSel = chipEn2;
      assign selected = !chipEnN;
    end
  endgenerate

  assign awake   = selected && sleepN;
  assign laneReq = {!hiByteEnN, !loByteEnN};

  always_comb begin
    strb.lanes = laneReq;
    strb.wr    = awake && !wrEnN && (laneReq != 2'b00);
    strb.rd    = awake && wrEnN && !outEnN && (laneReq != 2'b00);
  end
endmodule

// File: rtl/eccram_datapath.sv
module eccram_datapath
  import eccram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              injEn,
  input  logic [ADDR_W-1:0] injAddr,
  input  logic [CHK_W-1:0]  injBit,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        laneValid,
  output logic              errFlag
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / 2;

  logic [CW_W-1:0]   memArray [DEPTH];
  logic [CW_W-1:0]   storedCw;
  logic [CHK_W-1:0]  syndrome;
  logic [DATA_W-1:0] correctedWord;
  logic [DATA_W-1:0] mergedWord;
  logic [DATA_W-1:0] laneMask;

  assign storedCw      = memArray[addr];
  assign syndrome      = hamSyndrome(storedCw);
  assign correctedWord = hamCorrect(storedCw, syndrome);

  generate
    for (genvar g = 0; g < 2; g++) begin : g_lane
      assign mergedWord[g*LANE_W +: LANE_W] = strb.lanes[g] ? wrData[g*LANE_W +: LANE_W]
                                                            : correctedWord[g*LANE_W +: LANE_W];
      assign laneMask[g*LANE_W +: LANE_W]   = {LANE_W{strb.lanes[g]}};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strb.wr) begin
      memArray[addr] <= hamEncode(mergedWord);
    end else if (injEn && (int'(injBit) < CW_W)) begin
      memArray[injAddr][injBit] <= ~memArray[injAddr][injBit];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData    <= '0;
      laneValid <= 2'b00;
      errFlag   <= 1'b0;
    end else if (strb.rd) begin
      rdData    <= correctedWord & laneMask;
      laneValid <= strb.lanes;
      errFlag   <= (syndrome != '0);
    end else begin
      rdData    <= '0;
      laneValid <= 2'b00;
      errFlag   <= 1'b0;
    end
  end
endmodule

// File: rtl/eccram_core.sv
module eccram_core
  import eccram_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter bit DUAL_CE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chipEnN,
  input  logic              chipEn2,
  input  logic              wrEnN,
  input  logic              outEnN,
  input  logic              hiByteEnN,
  input  logic              loByteEnN,
  input  logic              sleepN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  input  logic              injEn,
  input  logic [ADDR_W-1:0] injAddr,
  input  logic [4:0]        injBit,
  output logic [15:0]       rdData,
  output logic [1:0]        laneValid,
  output logic              errFlag
);
  strobe_t strb;

  eccram_ctrl #(.DUAL_CE(DUAL_CE)) ctrl_i (
    .chipEnN(chipEnN), .chipEn2(chipEn2), .wrEnN(wrEnN), .outEnN(outEnN),
    .hiByteEnN(hiByteEnN), .loByteEnN(loByteEnN), .sleepN(sleepN), .strb(strb)
  );

  eccram_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .addr(addr), .wrData(wrData),
    .injEn(injEn), .injAddr(injAddr), .injBit(injBit),
    .rdData(rdData), .laneValid(laneValid), .errFlag(errFlag)
  );
endmodule

// File: rtl/eccram_checker.sv
module eccram_checker #(
  parameter bit DUAL_CE = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        chipEnN,
  input logic        chipEn2,
  input logic        wrEnN,
  input logic        outEnN,
  input logic        hiByteEnN,
  input logic        loByteEnN,
  input logic        sleepN,
  input logic [15:0] rdData,
  input logic [1:0]  laneValid,
  input logic        errFlag
);
  logic sel;
  assign sel = !chipEnN && (DUAL_CE ? chipEn2 : 1'b1);

  assert_deselect_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> laneValid == 2'b00);

  assert_no_enable_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (outEnN || (hiByteEnN && loByteEnN)) |=> laneValid == 2'b00);

  assert_sleep_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sleepN |=> (laneValid == 2'b00) && !errFlag);

  assert_write_no_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEnN |=> laneValid == 2'b00);

  assert_read_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && sleepN && wrEnN && !outEnN && !(hiByteEnN && loByteEnN))
      |=> laneValid == $past({!hiByteEnN, !loByteEnN}));

  assert_hi_lane_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !laneValid[1] |-> rdData[15:8] == 8'h00);

  assert_lo_lane_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !laneValid[0] |-> rdData[7:0] == 8'h00);

  assert_err_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag |-> laneValid != 2'b00);
endmodule

bind eccram_core eccram_checker #(.DUAL_CE(DUAL_CE)) chk_i (
  .clk(clk), .rst_n(rst_n), .chipEnN(chipEnN), .chipEn2(chipEn2), .wrEnN(wrEnN),
  .outEnN(outEnN), .hiByteEnN(hiByteEnN), .loByteEnN(loByteEnN), .sleepN(sleepN),
  .rdData(rdData), .laneValid(laneValid), .errFlag(errFlag)
);

// File: tb/eccram_core_tb_top.sv
`timescale 1ns/1ps
module eccram_core_tb_top;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chipEnN = 1'b1, chipEn2 = 1'b0, wrEnN = 1'b1, outEnN = 1'b1;
  logic hiByteEnN = 1'b1, loByteEnN = 1'b1, sleepN = 1'b1;
  logic [AW-1:0] addr = '0, injAddr = '0;
  logic [15:0] wrData = '0;
  logic injEn = 1'b0;
  logic [4:0] injBit = '0;
  logic [15:0] rdData;
  logic [1:0] laneValid;
  logic errFlag;

  always #2 clk = ~clk;

  eccram_core #(.ADDR_W(AW), .DUAL_CE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .chipEnN(chipEnN), .chipEn2(chipEn2), .wrEnN(wrEnN),
    .outEnN(outEnN), .hiByteEnN(hiByteEnN), .loByteEnN(loByteEnN), .sleepN(sleepN),
    .addr(addr), .wrData(wrData), .injEn(injEn), .injAddr(injAddr), .injBit(injBit),
    .rdData(rdData), .laneValid(laneValid), .errFlag(errFlag)
  );

  typedef struct {
    logic [1:0]  lanes;
    logic [15:0] data;
    logic        err;
    string       tag;
  } item_t;

  item_t expQ[$];
  logic [15:0] model [1 << AW];
  bit faulty [1 << AW];
  int nRun = 0, nFail = 0;
  bit finished = 0;

  // Driver: one bus operation per cycle; expected outcome computed from the requirements
  task automatic op(input logic ce1N, input logic ce2, input logic weN, input logic oeN,
                    input logic bhN, input logic blN, input logic slN,
                    input logic [AW-1:0] a, input logic [15:0] d, input string tag);
    item_t it;
    logic act, doWr, doRd;
    @(negedge clk);
    chipEnN = ce1N; chipEn2 = ce2; wrEnN = weN; outEnN = oeN;
    hiByteEnN = bhN; loByteEnN = blN; sleepN = slN; addr = a; wrData = d; injEn = 1'b0;
    act  = !ce1N && ce2 && slN;
    doWr = act && !weN && !(bhN && blN);
    doRd = act && weN && !oeN && !(bhN && blN);
    it.tag = tag; it.lanes = 2'b00; it.data = 16'h0; it.err = 1'b0;
    if (doRd) begin
      it.lanes = {!bhN, !blN};
      it.data  = model[a] & {{8{!bhN}}, {8{!blN}}};
      it.err   = faulty[a];
    end
    if (doWr) begin
      if (!bhN) model[a][15:8] = d[15:8];
      if (!blN) model[a][7:0]  = d[7:0];
      faulty[a] = 1'b0;
    end
    expQ.push_back(it);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input logic hi,
                    input logic lo, input string tag);
    op(1'b0, 1'b1, 1'b0, 1'b1, !hi, !lo, 1'b1, a, d, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic hi, input logic lo, input string tag);
    op(1'b0, 1'b1, 1'b1, 1'b0, !hi, !lo, 1'b1, a, 16'h0, tag);
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [4:0] b, input string tag);
    item_t it;
    @(negedge clk);
    chipEnN = 1'b1; wrEnN = 1'b1; outEnN = 1'b1; sleepN = 1'b1;
    injEn = 1'b1; injAddr = a; injBit = b;
    faulty[a] = 1'b1;
    it.tag = tag; it.lanes = 2'b00; it.data = 16'h0; it.err = 1'b0;
    expQ.push_back(it);
  endtask

  // Monitor: compares each cycle's outputs against the queued expectation
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      item_t e;
      e = expQ.pop_front();
      nRun++;
      if (laneValid !== e.lanes || rdData !== e.data || errFlag !== e.err) begin
        nFail++;
        $display("FAIL %s: got lanes=%b data=%h err=%b, expected lanes=%b data=%h err=%b",
                 e.tag, laneValid, rdData, errFlag, e.lanes, e.data, e.err);
      end
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    nRun++;
    if (rdData !== 16'h0 || laneValid !== 2'b00 || errFlag !== 1'b0) begin
      nFail++;
      $display("FAIL R9: got data=%h lanes=%b err=%b, expected 0000 00 0", rdData, laneValid, errFlag);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: full-word writes over a sweep, then read back
    for (int i = 0; i < 32; i++) wr(AW'(i), 16'(i * 16'h1357 ^ 16'hA5C3), 1'b1, 1'b1, "R1");
    for (int i = 0; i < 32; i++) rd(AW'(i), 1'b1, 1'b1, "R1");

    // R2: single-lane writes keep the other lane
    wr(10'd1, 16'hBEEF, 1'b1, 1'b0, "R2");
    rd(10'd1, 1'b1, 1'b1, "R2");
    wr(10'd2, 16'h1234, 1'b0, 1'b1, "R2");
    rd(10'd2, 1'b1, 1'b1, "R2");

    // R3: single-lane reads
    rd(10'd5, 1'b1, 1'b0, "R3");
    rd(10'd5, 1'b0, 1'b1, "R3");

    // R4: conditions that leave outputs undriven
    op(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 10'd6, 16'h0, "R4");
    op(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 10'd6, 16'h0, "R4");
    op(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 10'd6, 16'h0, "R4");
    op(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 10'd6, 16'h0, "R4");
    op(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd6, 16'hDEAD, "R4");
    op(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd6, 16'hDEAD, "R4");
    rd(10'd6, 1'b1, 1'b1, "R4");

    // R10: write wins over output enable
    op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd7, 16'h7E57, "R10");
    rd(10'd7, 1'b1, 1'b1, "R10");

    // R5: sleep blocks reads and writes, contents kept
    op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'd8, 16'h0, "R5");
    op(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd8, 16'hFFFF, "R5");
    op(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 10'd8, 16'h0, "R5");
    rd(10'd8, 1'b1, 1'b1, "R5");

    // R6: single flips in data and check positions, including the last position
    inject(10'd3, 5'd4, "R6");
    rd(10'd3, 1'b1, 1'b1, "R6");
    inject(10'd4, 5'd0, "R6");
    rd(10'd4, 1'b1, 1'b1, "R6");
    inject(10'd9, 5'd20, "R6");
    rd(10'd9, 1'b0, 1'b1, "R6");
    inject(10'd10, 5'd15, "R6");
    rd(10'd10, 1'b1, 1'b0, "R6");

    // R7: no write-back; repeated reads keep flagging
    rd(10'd3, 1'b1, 1'b1, "R7");
    rd(10'd4, 1'b1, 1'b1, "R7");

    // R8: partial write over a faulty word merges the corrected lane and cleans it
    wr(10'd3, 16'h00C4, 1'b0, 1'b1, "R8");
    rd(10'd3, 1'b1, 1'b1, "R8");
    wr(10'd9, 16'h5A00, 1'b1, 1'b0, "R8");
    rd(10'd9, 1'b1, 1'b1, "R8");

    op(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 10'd0, 16'h0, "R4");
    repeat (4) @(posedge clk);
    #2;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule